// File: doc/BRIEF.md
# Burst Memory Target on a Shared Address/Data Bus

This block is a synchronous bus target that serves open-ended burst reads and writes from an initiator. The initiator uses a frame signal and an initiator-ready signal. The target answers with a claim signal and a target-ready signal. In the first cycle of a transaction, the address/data lines carry the start address and the command lines carry the command. After that, the same lines carry data. A word moves on each rising edge at which both ready signals are high, and the target advances its word pointer after every such edge.

The target claims a transaction only when two conditions hold: the command is a memory read or a memory write, and the start address lies inside a window set by parameters. A claimed transaction is served from a small internal memory. Before the first word, the target holds its ready signal low for a fixed number of wait cycles. On reads, it leaves the shared lines undriven for one cycle so that the previous driver can let go of them. The initiator signals the last word by dropping frame while that word is still pending.

Top module: `pci_burst_target`

## Requirements
- R1: While reset is held and right after it is released, `tgt_claim`, `tgt_rdy` and `ad_oe` are low.
- R2: An address phase is a cycle in idle where `bus_frame` is high. The target claims the transaction (`tgt_claim` high in the next cycle) when `cmd_i` is 4'b0110 (read) or 4'b0111 (write) and `ad_i` lies in [BASE_ADDR, BASE_ADDR+WIN_BYTES).
- R3: Any other command, or an address outside the window, is ignored. `tgt_claim`, `tgt_rdy` and `ad_oe` stay low until `bus_frame` and `bus_irdy` are both low, and the memory is left unchanged.
- R4: A word moves only on a rising edge at which `bus_irdy` and `tgt_rdy` are both high. Initiator stall cycles neither lose nor repeat a word.
- R5: The word index starts at (address − BASE_ADDR)/4 and rises by one after each moved word. It wraps modulo the window depth (16 words by default).
- R6: The word that moves while `bus_frame` is low is the final one. In the next cycle, `tgt_claim`, `tgt_rdy` and `ad_oe` are low.
- R7: On a read, `ad_oe` is low in the first cycle after the address phase (the turnaround cycle). It is high from the second cycle on.
- R8: In each claimed transaction, `tgt_rdy` first rises 1+WAIT_STATES cycles after the address phase on a write, and 2+WAIT_STATES cycles after it on a read.
- R9: Words written by a burst are returned unchanged by later read bursts at the same word positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_frame | input | 1 | Initiator transaction frame, high while more than one word remains |
| bus_irdy | input | 1 | Initiator ready for the current word |
| ad_i | input | DW | Address in the address phase, write data afterwards |
| cmd_i | input | 4 | Command, valid in the address phase |
| ad_o | output | DW | Read data driven by the target |
| ad_oe | output | 1 | Target drives the shared data lines |
| tgt_rdy | output | 1 | Target ready for the current word |
| tgt_claim | output | 1 | Target has claimed the current transaction |

## Verification
The bench uses the default 64-byte window at 0x1000 (16 words of 32 bits) and WAIT_STATES=2. With 16 words, one burst can fill the whole memory, and a burst that starts near the end of the window wraps within a few words. With two wait cycles, the first-word latency is measured as a distinct count, not as a zero that a missing counter would also give. Initiator stalls are interleaved with target waits, and single-word bursts, foreign commands and addresses just outside both edges of the window are all exercised.

// File: rtl/pci_burst_target.sv
module pci_burst_target #(
  parameter int unsigned    DW          = 32,
  parameter logic [DW-1:0]  BASE_ADDR   = 'h1000,
  parameter int unsigned    WIN_BYTES   = 64,
  parameter int unsigned    WAIT_STATES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_frame,
  input  logic          bus_irdy,
  input  logic [DW-1:0] ad_i,
  input  logic [3:0]    cmd_i,
  output logic [DW-1:0] ad_o,
  output logic          ad_oe,
  output logic          tgt_rdy,
  output logic          tgt_claim
);
  localparam int unsigned BPW   = DW / 8;
  localparam int unsigned DEPTH = WIN_BYTES / BPW;
  localparam int unsigned IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned BW    = $clog2(BPW);
  localparam int unsigned WCW   = $clog2(WAIT_STATES + 2);
  localparam logic [DW-1:0] LIMIT = BASE_ADDR + DW'(WIN_BYTES);
  localparam logic [3:0] CMD_RD = 4'b0110;
  localparam logic [3:0] CMD_WR = 4'b0111;

  typedef enum logic [1:0] {S_IDLE, S_TURN, S_DATA, S_SKIP} st_t;

  st_t            state;
  logic           is_wr;
  logic [IW-1:0]  idx;
  logic [WCW-1:0] wcnt;
  logic [DW-1:0]  mem [DEPTH];

  wire in_win = (ad_i >= BASE_ADDR) && (ad_i < LIMIT);
  wire cmd_ok = (cmd_i == CMD_RD) || (cmd_i == CMD_WR);
  wire xfer   = tgt_rdy && bus_irdy;
  wire [IW-1:0] start_idx = IW'((ad_i - BASE_ADDR) >> BW);

  assign tgt_claim = (state == S_TURN) || (state == S_DATA);
  assign tgt_rdy   = (state == S_DATA) && (wcnt == '0);
  assign ad_oe     = (state == S_DATA) && !is_wr;
  assign ad_o      = ad_oe ? mem[idx] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      is_wr <= 1'b0;
      idx   <= '0;
      wcnt  <= '0;
    end else begin
      case (state)
        S_IDLE: if (bus_frame) begin
          if (in_win && cmd_ok) begin
            is_wr <= cmd_i[0];
            idx   <= start_idx;
            wcnt  <= WCW'(WAIT_STATES);
            state <= cmd_i[0] ? S_DATA : S_TURN;
          end else begin
            state <= S_SKIP;
          end
        end
        S_TURN: state <= S_DATA;
        S_DATA: begin
          if (wcnt != '0) wcnt <= wcnt - 1'b1;
          if (xfer) begin
            idx <= idx + 1'b1;
            if (!bus_frame) state <= S_IDLE;
          end
        end
        S_SKIP: if (!bus_frame && !bus_irdy) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (xfer && is_wr) mem[idx] <= ad_i;
  end
endmodule

module pci_burst_target_chk #(
  parameter int unsigned IW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_frame,
  input logic          bus_irdy,
  input logic          tgt_rdy,
  input logic          tgt_claim,
  input logic          ad_oe,
  input logic [IW-1:0] idx
);
  assert_rdy_needs_claim_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_rdy |-> tgt_claim);

  assert_idx_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_rdy && bus_irdy) |=> (idx == IW'($past(idx) + 1'b1)));

  assert_release_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_rdy && bus_irdy && !bus_frame) |=> !tgt_claim && !ad_oe);

  assert_turnaround_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ad_oe) |-> $past(tgt_claim) && !$past(ad_oe));

  assert_oe_needs_claim_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe |-> tgt_claim);
endmodule

bind pci_burst_target pci_burst_target_chk #(.IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_frame(bus_frame), .bus_irdy(bus_irdy),
  .tgt_rdy(tgt_rdy), .tgt_claim(tgt_claim), .ad_oe(ad_oe), .idx(idx)
);

// File: tb/pci_burst_target_bench.sv
module pci_burst_target_bench;
  localparam int unsigned DW = 32;
  localparam logic [31:0] BASE = 32'h1000;
  localparam int WAITS = 2;
  localparam int DEPTH = 16;

  logic clk = 0;
  logic rst_n = 0;
  logic bus_frame = 0, bus_irdy = 0;
  logic [DW-1:0] ad_i = '0;
  logic [3:0] cmd_i = '0;
  logic [DW-1:0] ad_o;
  logic ad_oe, tgt_rdy, tgt_claim;

  always #4 clk = ~clk;

  pci_burst_target #(.DW(DW), .BASE_ADDR(BASE), .WIN_BYTES(64), .WAIT_STATES(WAITS))
    u_pci_burst_target (
      .clk(clk), .rst_n(rst_n), .bus_frame(bus_frame), .bus_irdy(bus_irdy),
      .ad_i(ad_i), .cmd_i(cmd_i), .ad_o(ad_o), .ad_oe(ad_oe),
      .tgt_rdy(tgt_rdy), .tgt_claim(tgt_claim));

  int vec = 0, bad = 0;
  logic [31:0] model [DEPTH];
  logic [31:0] expq [$];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] wdata(input logic [31:0] a, input int i);
    return 32'hA500_0000 ^ (a << 8) ^ (32'h0101_0101 * i);
  endfunction

  // monitor: compare every read word moved on the next edge (R4, R9)
  always @(negedge clk) begin
    #1;
    if (rst_n && ad_oe && tgt_rdy && bus_irdy) begin
      if (expq.size() == 0) chk(1'b0, "R4 unexpected read word", ad_o, 32'h0);
      else begin
        logic [31:0] e;
        e = expq.pop_front();
        chk(ad_o === e, "R4/R9 read data", ad_o, e);
      end
    end
  end

  task automatic burst(input bit wr, input logic [31:0] addr, input int n, input bit stall);
    int b, i, cyc, lat;
    bit oe1, oe2, cl1;
    b = int'((addr - BASE) >> 2);
    if (!wr) for (int k = 0; k < n; k++) expq.push_back(model[(b + k) % DEPTH]);
    @(negedge clk);
    bus_frame = 1; bus_irdy = 0; cmd_i = wr ? 4'b0111 : 4'b0110; ad_i = addr;
    i = 0; cyc = 0; lat = -1; oe1 = 0; oe2 = 0; cl1 = 0;
    while (i < n && cyc < 200) begin
      @(negedge clk);
      cyc++;
      bus_irdy  = !(stall && (cyc % 3 == 0));
      bus_frame = bus_irdy ? (i < n - 1) : 1'b1;
      cmd_i = 4'b0000;
      ad_i  = wr ? wdata(addr, i) : 32'h0;
      #1;
      if (cyc == 1) begin oe1 = ad_oe; cl1 = tgt_claim; end
      if (cyc == 2) oe2 = ad_oe;
      if (tgt_rdy && lat < 0) lat = cyc;
      if (bus_irdy && tgt_rdy) begin
        if (wr) model[(b + i) % DEPTH] = wdata(addr, i);
        i++;
      end
    end
    @(negedge clk);
    bus_frame = 0; bus_irdy = 0; ad_i = 0;
    #1;
    chk(i == n, "R4 word count", i, n);
    chk(cl1, "R2 claim after address phase", cl1, 1);
    chk(lat == (wr ? 1 : 2) + WAITS, "R8 first ready latency", lat, (wr ? 1 : 2) + WAITS);
    if (!wr) chk(!oe1 && oe2, "R7 turnaround", {oe1, oe2}, 2'b01);
    chk(!tgt_claim && !tgt_rdy && !ad_oe, "R6 release after last word",
        {tgt_claim, tgt_rdy, ad_oe}, 0);
  endtask

  task automatic miss(input logic [3:0] cmd, input logic [31:0] addr);
    bit any;
    any = 0;
    @(negedge clk);
    bus_frame = 1; bus_irdy = 0; cmd_i = cmd; ad_i = addr;
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      bus_irdy = (c < 3); bus_frame = (c < 2); cmd_i = 0; ad_i = 32'hFFFF_FFFF;
      #1;
      any |= tgt_claim | tgt_rdy | ad_oe;
    end
    chk(!any, "R3 ignored transaction", any, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; vec++;
    $display("FAIL R4 watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 chk(!tgt_claim && !tgt_rdy && !ad_oe, "R1 in reset", {tgt_claim, tgt_rdy, ad_oe}, 0);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    #1 chk(!tgt_claim && !tgt_rdy && !ad_oe, "R1 after reset", {tgt_claim, tgt_rdy, ad_oe}, 0);

    burst(1, BASE, 16, 0);          // R9 fill
    burst(0, BASE, 16, 0);          // R9 readback
    burst(0, BASE + 32'h30, 5, 1);  // R5 wrap on read with stalls
    burst(1, BASE + 32'h3C, 3, 1);  // R5 wrap on write
    burst(0, BASE + 32'h38, 4, 0);
    miss(4'b0111, BASE - 4);        // R3 below window
    miss(4'b0110, BASE + 32'h40);   // R3 above window
    miss(4'b0010, BASE + 8);        // R3 foreign command
    miss(4'b0011, BASE + 8);
    burst(0, BASE, 16, 1);          // R3 memory untouched
    burst(1, BASE + 32'h14, 1, 0);  // single word
    burst(0, BASE + 32'h14, 1, 0);
    burst(0, BASE + 32'h10, 3, 1);

    repeat (3) @(negedge clk);
    chk(expq.size() == 0, "R4 all read words seen", expq.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule